// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents a single interrupt signal to a processor. Each line is captured into a pending register, either on a rising edge or by following the line's level, as software chooses. A mask register hides selected lines from arbitration. A fixed-priority resolver then compares the best unmasked pending line against every level already being serviced. Line 0 has the highest priority and line 7 the lowest.

The interrupt output is raised only when the winner outranks all levels in service, so a more urgent request can nest over a running handler. Equal and lower ones wait. On a synchronous acknowledge strobe the block returns an 8-bit vector on its data output and records the winning level as in service. The processor later retires that level with an end-of-interrupt command. A small register port with active-low select, read and write strobes and one address bit loads the mask and vector base, issues commands and reads back the pending, in-service and mask registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, pending = 0x00, in-service = 0x00, mask = 0xFF (all lines masked), vector base = 0, edge-triggered mode is selected, the status read select points at pending, and `intr` is low.
- R2: In edge mode, a 0-to-1 change on `irq_in[i]` sets pending bit i at the next clock edge. The bit stays set until its level is acknowledged. A line held high after acknowledge does not set the bit again.
- R3: In level mode, the pending register takes the value of `irq_in` at every clock edge. An acknowledge does not clear it.
- R4: A line whose mask bit is 1 never causes `intr`. Its pending bit is still recorded and readable.
- R5: `intr` is high exactly when some unmasked pending line exists and the lowest-numbered such line has a smaller index than every set in-service bit. A request at the same level as an in-service level, or at a lower priority, keeps `intr` low.
- R6: While `ack` is high and `intr` is high, `dbus_out` equals {base[4:0], winning index[2:0]}. At that clock edge the winner's in-service bit is set, and in edge mode its pending bit is cleared.
- R7: While `ack` is high and `intr` is low, `dbus_out` equals {base, 3'b111}, and no register changes because of the acknowledge.
- R8: A non-specific end-of-interrupt clears only the lowest-numbered set in-service bit. With no bit set, it changes nothing.
- R9: A write with `addr`=0 is decoded by priority. If bit 7 is 1, base is loaded from data bits 4:0. Otherwise, if bit 5 is 1, the write is an end-of-interrupt. Otherwise, bit 4 selects level mode (1) or edge mode (0), and bit 0 selects the status read (1 = in-service, 0 = pending).
- R10: A write with `addr`=1 loads the mask. A read with `addr`=1 returns the mask, and a read with `addr`=0 returns the register chosen by the status read select. With `cs_n` high, writes are ignored and `dbus_out` is 0x00 unless `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, bit 0 highest priority |
| cs_n | input | 1 | Active-low register select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, acts at each clock edge it is low |
| addr | input | 1 | Register address: 0 command/status, 1 mask |
| wdata | input | 8 | Write data |
| ack | input | 1 | Synchronous acknowledge from the processor, one cycle per grant |
| dbus_out | output | 8 | Vector during acknowledge, else read data, else zero |
| intr | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `ack` and every write strobe are synchronous and last one clock per intended action. They also assume that the in-service count changes by exactly one for a grant or an end-of-interrupt when the other is not in the same cycle, so the in-service checks exclude cycles in which both occur. The stimulus holds every strobe for a single cycle at a time, drawn from the same generator that picks random request patterns, masks and commands. A model written from the requirements is updated on each edge. Directed sequences first walk through nesting, blocking, spurious acknowledge, empty end-of-interrupt and deselected writes.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int unsigned NUM_IRQ = 8;
    parameter int unsigned DATA_W  = 8;
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ);
    localparam int unsigned BASE_W = DATA_W - LVL_W;

    // command byte bit positions (address 0 writes)
    localparam int unsigned CMD_BASE_BIT  = 7;
    localparam int unsigned CMD_EOI_BIT   = 5;
    localparam int unsigned CMD_LEVEL_BIT = 4;
    localparam int unsigned CMD_RSEL_BIT  = 0;

    typedef logic [NUM_IRQ-1:0] irq_vec_t;

    typedef struct packed {
        irq_vec_t pend;
        irq_vec_t prev;
    } req_state_t;

    typedef struct packed {
        irq_vec_t          mask;
        irq_vec_t          isr;
        logic [BASE_W-1:0] base;
        logic              level;
        logic              rsel;
    } ctl_state_t;

    // index of the lowest set bit, NUM_IRQ when none is set
    function automatic logic [LVL_W:0] first_set(irq_vec_t v);
        logic [LVL_W:0] r;
        r = (LVL_W+1)'(NUM_IRQ);
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (v[i]) r = (LVL_W+1)'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/pic_req_stage.sv
module pic_req_stage
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t irq,
    input  logic     level_mode,
    input  irq_vec_t clr,
    output irq_vec_t pend
);
    req_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq;
        if (level_mode) begin
            st_d.pend = irq;
        end else begin
            st_d.pend = (st_q.pend & ~clr) | (irq & ~st_q.prev);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  irq_vec_t         pend,
    input  irq_vec_t         mask,
    input  irq_vec_t         isr,
    output logic             intr,
    output logic [LVL_W-1:0] win_lvl
);
    irq_vec_t       cand;
    logic [LVL_W:0] req_idx;
    logic [LVL_W:0] svc_idx;

    always_comb begin
        cand    = pend & ~mask;
        req_idx = first_set(cand);
        svc_idx = first_set(isr);
        intr    = (cand != '0) && (req_idx < svc_idx);
        win_lvl = req_idx[LVL_W-1:0];
    end
endmodule

// File: rtl/pic_ctrl_regs.sv
module pic_ctrl_regs
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  logic              intr,
    input  logic [LVL_W-1:0]  win_lvl,
    input  irq_vec_t          pend,
    output irq_vec_t          mask,
    output irq_vec_t          isr,
    output logic              level_mode,
    output irq_vec_t          grant,
    output logic [DATA_W-1:0] dout
);
    ctl_state_t     st_d, st_q;
    logic           wr_en, rd_en, eoi;
    logic [LVL_W:0] top_svc;

    always_comb begin
        st_d    = st_q;
        wr_en   = !cs_n && !wr_n;
        rd_en   = !cs_n && !rd_n;
        eoi     = wr_en && !addr && !wdata[CMD_BASE_BIT] && wdata[CMD_EOI_BIT];
        top_svc = first_set(st_q.isr);
        grant   = '0;
        if (ack && intr) grant[win_lvl] = 1'b1;

        if (wr_en && addr) st_d.mask = wdata[NUM_IRQ-1:0];
        if (wr_en && !addr) begin
            if (wdata[CMD_BASE_BIT]) begin
                st_d.base = wdata[BASE_W-1:0];
            end else if (!wdata[CMD_EOI_BIT]) begin
                st_d.level = wdata[CMD_LEVEL_BIT];
                st_d.rsel  = wdata[CMD_RSEL_BIT];
            end
        end
        if (eoi && top_svc < (LVL_W+1)'(NUM_IRQ)) begin
            st_d.isr[top_svc[LVL_W-1:0]] = 1'b0;
        end
        st_d.isr = st_d.isr | grant;

        if (ack) begin
            dout = {st_q.base, intr ? win_lvl : LVL_W'(NUM_IRQ - 1)};
        end else if (rd_en) begin
            if (addr)           dout = DATA_W'(st_q.mask);
            else if (st_q.rsel) dout = DATA_W'(st_q.isr);
            else                dout = DATA_W'(pend);
        end else begin
            dout = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask       = st_q.mask;
    assign isr        = st_q.isr;
    assign level_mode = st_q.level;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] irq_in,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic       ack,
    output logic [7:0] dbus_out,
    output logic       intr
);
    irq_vec_t         pend_w, mask_w, isr_w, grant_w;
    logic             level_w;
    logic [LVL_W-1:0] win_lvl_w;

    pic_req_stage u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq        (irq_in),
        .level_mode (level_w),
        .clr        (grant_w),
        .pend       (pend_w)
    );

    pic_resolver u_res (
        .pend    (pend_w),
        .mask    (mask_w),
        .isr     (isr_w),
        .intr    (intr),
        .win_lvl (win_lvl_w)
    );

    pic_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .wdata      (wdata),
        .ack        (ack),
        .intr       (intr),
        .win_lvl    (win_lvl_w),
        .pend       (pend_w),
        .mask       (mask_w),
        .isr        (isr_w),
        .level_mode (level_w),
        .grant      (grant_w),
        .dout       (dbus_out)
    );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              addr,
    input logic              base_bit,
    input logic              eoi_bit,
    input logic              ack,
    input logic              intr,
    input logic [DATA_W-1:0] dbus_out,
    input irq_vec_t          pend,
    input irq_vec_t          mask,
    input irq_vec_t          isr,
    input logic [LVL_W-1:0]  win_lvl
);
    logic eoi_cmd;
    assign eoi_cmd = !cs_n && !wr_n && !addr && !base_bit && eoi_bit;

    AST_INTR_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((pend & ~mask) != '0)); // R4

    AST_GRANT_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && intr && !eoi_cmd) |=> ($countones(isr) == $countones($past(isr)) + 1)
                                      && isr[$past(win_lvl)]); // R6

    AST_SPURIOUS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !intr) |-> (dbus_out[LVL_W-1:0] == LVL_W'(NUM_IRQ - 1))); // R7

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !ack && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8

    AST_SERVICE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !eoi_cmd) |=> $stable(isr)); // R8
endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .base_bit (wdata[7]),
    .eoi_bit  (wdata[5]),
    .ack      (ack),
    .intr     (intr),
    .dbus_out (dbus_out),
    .pend     (pend_w),
    .mask     (mask_w),
    .isr      (isr_w),
    .win_lvl  (win_lvl_w)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] dbus_out;
    logic       intr;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_pend = '0, m_isr = '0, m_mask = 8'hFF, m_prev = '0;
    logic [4:0] m_base = '0;
    logic       m_level = 1'b0, m_rsel = 1'b0;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .wdata(wdata), .ack(ack),
        .dbus_out(dbus_out), .intr(intr)
    );

    always #2 clk = ~clk;

    function automatic int low_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_intr();
        logic [7:0] c;
        c = m_pend & ~m_mask;
        return (c != 0) && (low_idx(c) < low_idx(m_isr));
    endfunction

    function automatic logic [7:0] exp_dout();
        int h;
        h = low_idx(m_pend & ~m_mask);
        if (ack) return {m_base, exp_intr() ? 3'(h) : 3'd7};
        if (!cs_n && !rd_n) return addr ? m_mask : (m_rsel ? m_isr : m_pend);
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [7:0] c, ni, np;
        int h, s;
        logic g, w;
        c = m_pend & ~m_mask;
        h = low_idx(c);
        s = low_idx(m_isr);
        g = exp_intr();
        w = !cs_n && !wr_n;
        ni = m_isr;
        if (w && !addr && !wdata[7] && wdata[5] && s < 8) ni[s] = 1'b0;
        if (ack && g) ni[h] = 1'b1;
        if (m_level) np = irq_in;
        else begin
            np = m_pend;
            if (ack && g) np[h] = 1'b0;
            np = np | (irq_in & ~m_prev);
        end
        if (w && addr) m_mask = wdata;
        if (w && !addr) begin
            if (wdata[7]) m_base = wdata[4:0];
            else if (!wdata[5]) begin
                m_level = wdata[4];
                m_rsel  = wdata[0];
            end
        end
        m_isr = ni;
        m_pend = np;
        m_prev = irq_in;
    endtask

    // inputs are set after a falling edge; compare, then let the edge happen
    task automatic cyc(input string tag);
        #1;
        chk(tag, "intr", {7'd0, intr}, {7'd0, exp_intr()});
        chk(tag, "dbus_out", dbus_out, exp_dout());
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ack = 1'b0;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d, input string tag);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        cyc(tag);
        idle();
    endtask

    task automatic rd_reg(input logic a, input string tag);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        cyc(tag);
        idle();
    endtask

    task automatic do_ack(input string tag);
        ack = 1'b1;
        cyc(tag);
        ack = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc("R1");
        rd_reg(1'b1, "R1");
        rd_reg(1'b0, "R1");
        wr_reg(1'b0, 8'h01, "R9");
        rd_reg(1'b0, "R1");
        wr_reg(1'b0, 8'h00, "R9");
        // R4 masked line recorded but silent
        irq_in = 8'h08;
        cyc("R2");
        cyc("R4");
        rd_reg(1'b0, "R4");
        wr_reg(1'b1, 8'h00, "R10");
        cyc("R5");
        // R6 grant with base 0
        do_ack("R6");
        rd_reg(1'b0, "R2");
        wr_reg(1'b0, 8'h95, "R9");
        // R5 nesting over level 3
        irq_in = 8'h0A;
        cyc("R5");
        cyc("R5");
        do_ack("R6");
        // lower request blocked
        irq_in = 8'h2A;
        cyc("R5");
        cyc("R5");
        wr_reg(1'b0, 8'h01, "R9");
        rd_reg(1'b0, "R6");
        wr_reg(1'b0, 8'h20, "R8");
        cyc("R5");
        wr_reg(1'b0, 8'h20, "R8");
        cyc("R5");
        do_ack("R6");
        rd_reg(1'b0, "R8");
        wr_reg(1'b0, 8'h20, "R8");
        wr_reg(1'b0, 8'h20, "R8");
        rd_reg(1'b0, "R8");
        // R7 spurious acknowledge
        do_ack("R7");
        rd_reg(1'b0, "R7");
        // R3 level mode
        wr_reg(1'b0, 8'h10, "R3");
        irq_in = 8'h40;
        cyc("R3");
        rd_reg(1'b0, "R3");
        do_ack("R3");
        rd_reg(1'b0, "R3");
        irq_in = 8'h00;
        cyc("R3");
        do_ack("R7");
        wr_reg(1'b0, 8'h20, "R8");
        // R10 deselected write ignored
        cs_n = 1'b1; wr_n = 1'b0; addr = 1'b1; wdata = 8'h5A;
        cyc("R10");
        idle();
        rd_reg(1'b1, "R10");
        cs_n = 1'b1; rd_n = 1'b0;
        cyc("R10");
        idle();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ 8'($urandom_range(0, 255));
            if (r < 10) begin
                ack = 1'b1;
            end else if (r < 16) begin
                cs_n = 1'b0; wr_n = 1'b0; addr = 1'b1; wdata = 8'($urandom_range(0, 255));
            end else if (r < 28) begin
                cs_n = 1'b0; wr_n = 1'b0; addr = 1'b0; wdata = 8'($urandom_range(0, 255));
            end else if (r < 50) begin
                cs_n = 1'b0; rd_n = 1'b0; addr = 1'($urandom_range(0, 1));
            end
            cyc("R5");
            idle();
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule